// File: doc/BRIEF.md
# DDR2 Direct Command Encoder

This block sits between a software-visible command register and the command pins of a DDR2 memory interface. Software writes a 32-bit command word. The block decodes the command type, the target rank, the bank and the operand. It then drives one DDR2 command for exactly one clock cycle on the chip selects, RAS#, CAS#, WE#, the bank address and the address pins. This is the path used to bring a memory device up: deselect with clock enable, precharge-all, the four mode-register writes and auto-refreshes, all issued by software one after another.

A single holding slot lets software write while the previous command is still inside its minimum spacing window. `busy` stays high while the slot is occupied, and a write presented during `busy` waits on the bus until it can be taken. Clock enable is low from reset and rises permanently with the first NOP. Command codes that are not recognised never reach the pins and set a sticky error flag.

Top module: `ddr_dcmd_encoder`

## Requirements
- R1: After reset all chip selects are high, RAS#, CAS# and WE# are high, `addr` and `ba` are zero, `cke` is low, and both `busy` and `cmd_err` are low.
- R2: Command code 0x0 in bits 27:24 is a mode-register write. It drives RAS#, CAS# and WE# low, puts bits 18:16 on `ba` (0 = MRS, 1..3 = EMRS1..EMRS3) and puts the low ADDR_W bits of bits 15:0 on `addr`.
- R3: Code 0x1 is precharge-all. It drives RAS# and WE# low and CAS# high, with `addr` bit 10 high, every other `addr` bit low and `ba` zero.
- R4: Code 0x5 is auto-refresh. It drives RAS# and CAS# low and WE# high, with `addr` and `ba` zero.
- R5: Code 0x7 is NOP. It drives RAS#, CAS# and WE# high with the selected chip select low. `cke` goes high in the same cycle the NOP appears and stays high until reset.
- R6: Bit 20 of the word picks the rank: 0 drives `cs_n[0]` low and 1 drives `cs_n[1]` low. The other chip select stays high. Each command lasts one cycle, and between commands all pins return to the idle state of R1.
- R7: A write taken on clock edge E while no command spacing is pending appears on the pins after edge E+1. Two successive commands start at least MIN_GAP cycles apart.
- R8: `busy` is high exactly while a decoded command waits in the holding slot. A write is taken only while `busy` is low. Commands reach the pins strictly in the order they were taken.
- R9: A word whose code is not 0x0, 0x1, 0x5 or 0x7 causes no pin activity. It sets `cmd_err` one cycle after it is taken, and `cmd_err` then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | 32 | Command word |
| busy | output | 1 | Holding slot occupied; writes are not taken |
| cmd_err | output | 1 | Sticky flag for an unknown command code |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 2 | Per-rank chip selects, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | ADDR_W | Address / mode-register operand |

## Verification
The hardest state to reach is a full holding slot while the spacing counter is still running. In that state a further write must stall on the bus and must not overtake or overwrite the waiting command. The stimulus reaches it by writing the full device bring-up sequence, for both ranks, with no idle cycles between writes. This keeps `busy` asserted for most of the run. An unknown code is also placed inside that stream, so its effect on the pins and on ordering is seen under pressure. Isolated writes after long idle periods then check the minimum latency, and an operand with bits above the address width checks truncation.

// File: rtl/ddr_dcmd_pkg.sv
package ddr_dcmd_pkg;

   localparam int NUM_RANKS  = 2;
   localparam int CODE_LSB   = 24;
   localparam int CODE_W     = 4;
   localparam int RANK_BIT   = 20;
   localparam int BANK_LSB   = 16;
   localparam int BANK_W     = 3;
   localparam int OPND_W     = 16;
   localparam int PALL_BIT   = 10;

   typedef enum logic [CODE_W-1:0] {
      CODE_MODE = 4'h0,
      CODE_PALL = 4'h1,
      CODE_AREF = 4'h5,
      CODE_NOP  = 4'h7
   } dcmd_code_e;

   typedef struct packed {
      logic              ras_n;
      logic              cas_n;
      logic              we_n;
      logic              rank;
      logic [BANK_W-1:0] ba;
      logic [OPND_W-1:0] opnd;
      logic              set_cke;
   } dcmd_pins_t;

   localparam dcmd_pins_t PINS_IDLE = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                                        rank: 1'b0, ba: '0, opnd: '0, set_cke: 1'b0};

endpackage

// File: rtl/ddr_dcmd_decode.sv
module ddr_dcmd_decode
   import ddr_dcmd_pkg::*;
(
   input  logic [31:0] word,
   output dcmd_pins_t  pins,
   output logic        known
);

   logic [CODE_W-1:0] code;
   assign code = word[CODE_LSB +: CODE_W];

   always_comb begin
      pins      = PINS_IDLE;
      pins.rank = word[RANK_BIT];
      known     = 1'b1;
      unique case (code)
         CODE_MODE: begin
            pins.ras_n = 1'b0;
            pins.cas_n = 1'b0;
            pins.we_n  = 1'b0;
            pins.ba    = word[BANK_LSB +: BANK_W];
            pins.opnd  = word[OPND_W-1:0];
         end
         CODE_PALL: begin
            pins.ras_n          = 1'b0;
            pins.we_n           = 1'b0;
            pins.opnd[PALL_BIT] = 1'b1;
         end
         CODE_AREF: begin
            pins.ras_n = 1'b0;
            pins.cas_n = 1'b0;
         end
         CODE_NOP: begin
            pins.set_cke = 1'b1;
         end
         default: begin
            known = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/ddr_dcmd_slot.sv
module ddr_dcmd_slot
   import ddr_dcmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  dcmd_pins_t din,
   input  logic       take,
   output logic       full,
   output dcmd_pins_t dout
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= PINS_IDLE;
      end else begin
         if (load) begin
            full <= 1'b1;
            dout <= din;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end

   // R8: the slot is never overwritten while it holds a command
   a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !load);

   // R8: a waiting command that is not taken keeps its content
   a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !take) |=> (full && $stable(dout)));

endmodule

// File: rtl/ddr_dcmd_gap.sv
module ddr_dcmd_gap #(
   parameter int MIN_GAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ready
);

   generate
      if (MIN_GAP <= 1) begin : g_nogap
         assign ready = 1'b1;
      end else begin : g_count
         localparam int CNT_W = $clog2(MIN_GAP);
         localparam logic [CNT_W-1:0] RELOAD = CNT_W'(MIN_GAP - 1);
         logic [CNT_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)            cnt <= '0;
            else if (start)        cnt <= RELOAD;
            else if (cnt != '0)    cnt <= cnt - 1'b1;
         end
         assign ready = (cnt == '0);

         // R7: a new start is only requested once the window has run out
         a_r7_start_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> ready);
      end
   endgenerate

endmodule

// File: rtl/ddr_dcmd_encoder.sv
module ddr_dcmd_encoder
   import ddr_dcmd_pkg::*;
#(
   parameter int ADDR_W  = 14,
   parameter int MIN_GAP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [31:0]       wr_data,
   output logic              busy,
   output logic              cmd_err,
   output logic              cke,
   output logic [NUM_RANKS-1:0] cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ADDR_W-1:0] addr
);

   generate
      if (ADDR_W <= PALL_BIT || ADDR_W > OPND_W) begin : g_bad_addr_w
         $error("ADDR_W must lie between %0d and %0d", PALL_BIT + 1, OPND_W);
      end
      if (MIN_GAP < 1) begin : g_bad_gap
         $error("MIN_GAP must be at least 1");
      end
   endgenerate

   dcmd_pins_t dec_pins, slot_pins;
   logic       dec_known, slot_full, gap_ready, accept, issue;

   ddr_dcmd_decode u_decode (
      .word  (wr_data),
      .pins  (dec_pins),
      .known (dec_known)
   );

   assign accept = wr_en && !slot_full;
   assign issue  = slot_full && gap_ready;

   ddr_dcmd_slot u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept && dec_known),
      .din   (dec_pins),
      .take  (issue),
      .full  (slot_full),
      .dout  (slot_pins)
   );

   ddr_dcmd_gap #(.MIN_GAP(MIN_GAP)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .start (issue),
      .ready (gap_ready)
   );

   assign busy = slot_full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_n   <= 1'b1;
         cas_n   <= 1'b1;
         we_n    <= 1'b1;
         ba      <= '0;
         addr    <= '0;
         cke     <= 1'b0;
         cmd_err <= 1'b0;
      end else begin
         if (accept && !dec_known) cmd_err <= 1'b1;
         if (issue) begin
            ras_n <= slot_pins.ras_n;
            cas_n <= slot_pins.cas_n;
            we_n  <= slot_pins.we_n;
            ba    <= slot_pins.ba;
            addr  <= slot_pins.opnd[ADDR_W-1:0];
            if (slot_pins.set_cke) cke <= 1'b1;
         end else begin
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            ba    <= '0;
            addr  <= '0;
         end
      end
   end

   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank_cs
      always_ff @(posedge clk) begin
         if (!rst_n) cs_n[r] <= 1'b1;
         else        cs_n[r] <= !(issue && (slot_pins.rank == r[0]));
      end
   end

   // ---------------- assertions ----------------
   logic any_cs;
   assign any_cs = ~&cs_n;

   // R6: never more than one rank selected
   a_r6_one_rank: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R6: with no rank selected the strobes are idle
   a_r6_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !any_cs |-> (ras_n && cas_n && we_n));

   // R3: precharge-all pattern carries address bit 10
   a_r3_pall_a10: assert property (@(posedge clk) disable iff (!rst_n)
      (any_cs && !ras_n && cas_n && !we_n) |-> addr[PALL_BIT]);

   // R5: clock enable never falls once raised
   a_r5_cke_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);

   // R5: clock enable only rises together with a NOP on the pins
   a_r5_cke_rise_nop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (any_cs && ras_n && cas_n && we_n));

   // R9: error flag is sticky
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   // R7: spacing between pin commands, watched by an independent counter
   localparam int SW = $clog2(MIN_GAP + 2);
   logic [SW-1:0] since_cmd;
   logic          seen_cmd;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_cmd <= '0;
         seen_cmd  <= 1'b0;
      end else if (any_cs) begin
         since_cmd <= SW'(1);
         seen_cmd  <= 1'b1;
      end else if (since_cmd < SW'(MIN_GAP)) begin
         since_cmd <= since_cmd + 1'b1;
      end
   end

   a_r7_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (any_cs && seen_cmd) |-> (since_cmd >= SW'(MIN_GAP)));

endmodule

// File: tb/ddr_dcmd_encoder_tb.sv
module ddr_dcmd_encoder_tb;

   localparam int ADDR_W  = 14;
   localparam int MIN_GAP = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [31:0]       wr_data = '0;
   logic              busy, cmd_err, cke, ras_n, cas_n, we_n;
   logic [1:0]        cs_n;
   logic [2:0]        ba;
   logic [ADDR_W-1:0] addr;

   always #2 clk = ~clk;   // 250 MHz

   ddr_dcmd_encoder #(.ADDR_W(ADDR_W), .MIN_GAP(MIN_GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .busy(busy), .cmd_err(cmd_err), .cke(cke), .cs_n(cs_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   bit          m_pend_v = 0;
   logic [31:0] m_pend;
   int          m_gap = 0;
   logic [1:0]  e_cs = 2'b11;
   logic        e_ras = 1, e_cas = 1, e_we = 1, e_cke = 0, e_err = 0;
   logic [2:0]  e_ba = 0;
   logic [ADDR_W-1:0] e_addr = 0;
   string       e_tag = "R6";
   bit          m_acc = 0;
   int          cyc = 0;
   int          last_cmd_cyc = -1000;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_apply(input logic [31:0] w);
      e_cs[w[20]] = 1'b0;
      case (w[27:24])
         4'h0: begin
            e_ras = 0; e_cas = 0; e_we = 0;
            e_ba = w[18:16]; e_addr = w[ADDR_W-1:0]; e_tag = "R2";
         end
         4'h1: begin
            e_ras = 0; e_cas = 1; e_we = 0;
            e_addr = '0; e_addr[10] = 1'b1; e_tag = "R3";
         end
         4'h5: begin
            e_ras = 0; e_cas = 0; e_we = 1; e_tag = "R4";
         end
         default: begin
            e_ras = 1; e_cas = 1; e_we = 1; e_cke = 1; e_tag = "R5";
         end
      endcase
   endtask

   task automatic step();
      bit old_busy;
      @(negedge clk);
      cyc++;
      old_busy = m_pend_v;
      e_cs = 2'b11; e_ras = 1; e_cas = 1; e_we = 1; e_ba = 0; e_addr = 0;
      e_tag = "R6";
      if (m_pend_v && m_gap == 0) begin
         model_apply(m_pend);
         m_pend_v = 0;
         m_gap = MIN_GAP - 1;
      end else if (m_gap > 0) begin
         m_gap--;
      end
      m_acc = wr_en && !old_busy;
      if (m_acc) begin
         if (wr_data[27:24] inside {4'h0, 4'h1, 4'h5, 4'h7}) begin
            m_pend_v = 1; m_pend = wr_data;
         end else begin
            e_err = 1;
         end
      end
      // compare every cycle
      chk(cs_n === e_cs, {e_tag, " R6 R7"}, "cs_n", 32'(cs_n), 32'(e_cs));
      chk({ras_n, cas_n, we_n} === {e_ras, e_cas, e_we}, {e_tag, " R7"}, "ras/cas/we",
          32'({ras_n, cas_n, we_n}), 32'({e_ras, e_cas, e_we}));
      chk(ba === e_ba && addr === e_addr, e_tag, "ba/addr",
          32'({ba, addr}), 32'({e_ba, e_addr}));
      chk(busy === m_pend_v, "R8", "busy", 32'(busy), 32'(m_pend_v));
      chk(cke === e_cke, "R5", "cke", 32'(cke), 32'(e_cke));
      chk(cmd_err === e_err, "R9", "cmd_err", 32'(cmd_err), 32'(e_err));
      // R7: spacing measured on the pins
      if (cs_n !== 2'b11) begin
         chk(cyc - last_cmd_cyc >= MIN_GAP, "R7", "command spacing",
             32'(cyc - last_cmd_cyc), 32'(MIN_GAP));
         last_cmd_cyc = cyc;
      end
   endtask

   task automatic send(input logic [31:0] w);
      wr_en = 1; wr_data = w;
      step();
      while (!m_acc) step();
      wr_en = 0; wr_data = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic bringup(input bit rank);
      logic [31:0] rb;
      rb = rank ? 32'h0010_0000 : 32'h0;
      send(32'h0700_0000 | rb);   // NOP
      send(32'h0100_0000 | rb);   // precharge all
      send(32'h0002_0000 | rb);   // EMRS2
      send(32'h0003_0000 | rb);   // EMRS3
      send(32'h0001_0400 | rb);   // EMRS1
      send(32'h0000_0542 | rb);   // MRS with DLL reset
      send(32'h0100_0000 | rb);   // precharge all
      send(32'h0500_0000 | rb);   // refresh
      send(32'h0500_0000 | rb);   // refresh
      send(32'h0000_0442 | rb);   // MRS
      send(32'h0001_0780 | rb);   // EMRS1 OCD default
      send(32'h0001_0400 | rb);   // EMRS1 OCD exit
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(cs_n === 2'b11, "R1", "cs_n", 32'(cs_n), 32'h3);
      chk({ras_n, cas_n, we_n} === 3'b111, "R1", "strobes", 32'({ras_n, cas_n, we_n}), 32'h7);
      chk(ba === 0 && addr === 0, "R1", "ba/addr", 32'({ba, addr}), 32'h0);
      chk(cke === 1'b0, "R1", "cke", 32'(cke), 32'h0);
      chk(busy === 1'b0 && cmd_err === 1'b0, "R1", "busy/err", 32'({busy, cmd_err}), 32'h0);
      rst_n = 1;
      idle(3);
      // R2 R3 R4: isolated refresh before NOP, cke still low; R7 latency
      send(32'h0500_0000);
      idle(6);
      // full bring-up back to back, both ranks
      bringup(1'b0);
      // R9: unknown code in the stream
      send(32'h0300_0000);
      send(32'h0010_0000 | 32'h0400_0542);
      bringup(1'b1);
      idle(8);
      // R2: operand wider than the address pins is truncated
      send(32'h0001_C542);
      idle(8);
      // R6 R8: alternate ranks back to back
      send(32'h0510_0000);
      send(32'h0500_0000);
      send(32'h0111_0000);
      send(32'h0F00_FFFF);
      send(32'h0013_0ABC);
      idle(10);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule